// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a virtual address into a physical mapping by walking a two-level translation table held in physical memory. A request starts after a lookup miss in the translation cache; the walker reads a first-level descriptor through a single-request memory read port, decodes it, and either finishes at once with a 1 MB section or reads one second-level descriptor from a coarse or a fine table. It never makes more than two reads per walk.

The result is the page base address, a mapping-size code, the 4-bit domain and eight bits of access permission (four 2-bit subpage fields), or a translation fault that names the level at which the walk stopped. Permission checking, result caching and any address modification before the walk belong to neighbouring blocks.

Top module: `ptw_walker`

## Requirements
- R1: After reset, `busy`, `done`, `fault` and `mem_req` are all low.
- R2: The first read goes to `{tbl_base[31:14], va[31:20], 2'b00}`.
- R3: A first-level descriptor whose bits [1:0] are 2'b10 is a section: the walk ends after one read with `pa_base = {desc[31:20], 20'b0}`, `map_size = 0`, `domain = desc[8:5]` and `ap` holding `desc[11:10]` in all four 2-bit slots.
- R4: First-level type 2'b01 points to a coarse table; the second read goes to `{desc[31:10], va[19:12], 2'b00}`, and the domain of the result is the pointer's `desc[8:5]`.
- R5: First-level type 2'b11 points to a fine table; the second read goes to `{desc[31:12], va[19:10], 2'b00}`, and the domain of the result is the pointer's `desc[8:5]`.
- R6: A second-level descriptor of type 2'b01 is a 64 KB large page (`pa_base = {d[31:16],16'b0}`, `map_size = 1`, `ap = d[11:4]`); type 2'b10 is a 4 KB small page (`pa_base = {d[31:12],12'b0}`, `map_size = 2`, `ap = d[11:4]`).
- R7: A second-level descriptor of type 2'b11 read from a fine table is a 1 KB tiny page: `pa_base = {d[31:10],10'b0}`, `map_size = 3`, `ap` holding `d[5:4]` in all four slots.
- R8: First-level type 2'b00 ends the walk after one read with `fault = 1` and `fault_level = 0`; `pa_base`, `map_size`, `domain` and `ap` are zero.
- R9: Second-level type 2'b00, or type 2'b11 read from a coarse table, ends the walk with `fault = 1` and `fault_level = 1`, and all result fields zero.
- R10: `done` is high for exactly one cycle per walk, `fault` is high only in that cycle, and `busy` stays high from the cycle after the accepted `start` up to and including the `done` cycle.
- R11: `start` while `busy` is high is ignored: no extra read is made and the running walk's result is unchanged.
- R12: `mem_req` is a one-cycle pulse, is raised only while `busy`, and no new request is issued before the previous read's `mem_rvalid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a walk (taken only when idle) |
| va | input | 32 | Address to translate, sampled with start |
| tbl_base | input | 32 | First-level table base, sampled with start |
| busy | output | 1 | Walk in progress |
| mem_req | output | 1 | One-cycle memory read request |
| mem_addr | output | 32 | Read address, valid with mem_req |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |
| done | output | 1 | One-cycle completion strobe |
| fault | output | 1 | Translation fault, valid with done |
| fault_level | output | 1 | 0 = first level, 1 = second level |
| pa_base | output | 32 | Physical base of the mapping |
| map_size | output | 2 | 0 = 1 MB, 1 = 64 KB, 2 = 4 KB, 3 = 1 KB |
| domain | output | 4 | Domain of the mapping |
| ap | output | 8 | Four 2-bit subpage permission fields |

## Verification
On every cycle the assertions check the handshake shape: the single-cycle `done` and `mem_req` pulses, requests only while busy with one read outstanding, `fault` only in the `done` cycle with zero result fields, and `busy` falling only right after `done`. What they cannot see is whether the addresses and decoded fields are right for a given descriptor; the bench's scenarios show that, covering every descriptor type at both levels, the tiny-in-coarse fault, varied memory latency, and a `start` pulse issued mid-walk that must leave the read count and the result untouched.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

    localparam int PTW_AW      = 32;
    localparam int PTW_DOM_W   = 4;
    localparam int PTW_AP_W    = 8;
    localparam int PTW_SUBPAGE = 4;

    typedef enum logic [1:0] {
        SZ_1M  = 2'd0,
        SZ_64K = 2'd1,
        SZ_4K  = 2'd2,
        SZ_1K  = 2'd3
    } map_size_e;

    typedef enum logic [1:0] {
        L1_FAULT   = 2'b00,
        L1_COARSE  = 2'b01,
        L1_SECTION = 2'b10,
        L1_FINE    = 2'b11
    } l1_kind_e;

    typedef enum logic [1:0] {
        L2_FAULT = 2'b00,
        L2_LARGE = 2'b01,
        L2_SMALL = 2'b10,
        L2_TINY  = 2'b11
    } l2_kind_e;

    typedef struct packed {
        logic [PTW_AW-1:0]    pa;
        map_size_e            size;
        logic [PTW_DOM_W-1:0] dom;
        logic [PTW_AP_W-1:0]  ap;
    } xlat_t;

    localparam xlat_t XLAT_ZERO = '{pa: '0, size: SZ_1M, dom: '0, ap: '0};

    // Spread one 2-bit permission over every subpage slot.
    function automatic logic [PTW_AP_W-1:0] spread_ap(input logic [1:0] a);
        return {PTW_SUBPAGE{a}};
    endfunction

endpackage

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen
    import ptw_pkg::*;
#(
    parameter int AW        = PTW_AW,
    parameter int L1_IDX_W  = 12,
    parameter int CRS_IDX_W = 8,
    parameter int FIN_IDX_W = 10
) (
    input  logic [AW-1:0] va,
    input  logic [AW-1:0] tbl_base,
    input  logic [AW-1:0] l1_desc,
    input  logic          fine_sel,
    output logic [AW-1:0] l1_addr,
    output logic [AW-1:0] l2_addr
);
    localparam int L1_LO   = AW - L1_IDX_W;       // lowest VA bit of first index
    localparam int BASE_LO = L1_IDX_W + 2;        // table alignment
    localparam int CRS_LO  = L1_LO - CRS_IDX_W;   // lowest VA bit of coarse index
    localparam int FIN_LO  = L1_LO - FIN_IDX_W;   // lowest VA bit of fine index
    localparam int CRS_AL  = CRS_IDX_W + 2;
    localparam int FIN_AL  = FIN_IDX_W + 2;

    logic [AW-1:0] crs_addr;
    logic [AW-1:0] fin_addr;

    always_comb begin
        l1_addr  = {tbl_base[AW-1:BASE_LO], va[AW-1:L1_LO], 2'b00};
        crs_addr = {l1_desc[AW-1:CRS_AL], va[L1_LO-1:CRS_LO], 2'b00};
        fin_addr = {l1_desc[AW-1:FIN_AL], va[L1_LO-1:FIN_LO], 2'b00};
        l2_addr  = fine_sel ? fin_addr : crs_addr;
    end
endmodule

// File: rtl/ptw_l1_decode.sv
module ptw_l1_decode
    import ptw_pkg::*;
#(
    parameter int AW = PTW_AW
) (
    input  logic [AW-1:0] desc,
    output l1_kind_e      kind,
    output xlat_t         sect
);
    localparam int SECT_LO = 20;

    always_comb begin
        kind      = l1_kind_e'(desc[1:0]);
        sect      = XLAT_ZERO;
        sect.pa   = {desc[AW-1:SECT_LO], {SECT_LO{1'b0}}};
        sect.size = SZ_1M;
        sect.dom  = desc[8:5];
        sect.ap   = spread_ap(desc[11:10]);
    end
endmodule

// File: rtl/ptw_l2_decode.sv
module ptw_l2_decode
    import ptw_pkg::*;
#(
    parameter int AW = PTW_AW
) (
    input  logic [AW-1:0]        desc,
    input  logic                 fine_tbl,
    input  logic [PTW_DOM_W-1:0] dom_in,
    output logic                 flt,
    output xlat_t                res
);
    localparam int LARGE_LO = 16;
    localparam int SMALL_LO = 12;
    localparam int TINY_LO  = 10;

    l2_kind_e kind;

    always_comb begin
        kind    = l2_kind_e'(desc[1:0]);
        flt     = 1'b0;
        res     = XLAT_ZERO;
        res.dom = dom_in;
        unique case (kind)
            L2_LARGE: begin
                res.pa   = {desc[AW-1:LARGE_LO], {LARGE_LO{1'b0}}};
                res.size = SZ_64K;
                res.ap   = desc[11:4];
            end
            L2_SMALL: begin
                res.pa   = {desc[AW-1:SMALL_LO], {SMALL_LO{1'b0}}};
                res.size = SZ_4K;
                res.ap   = desc[11:4];
            end
            L2_TINY: begin
                res.pa   = {desc[AW-1:TINY_LO], {TINY_LO{1'b0}}};
                res.size = SZ_1K;
                res.ap   = spread_ap(desc[5:4]);
                flt      = !fine_tbl;
            end
            default: flt = 1'b1;
        endcase
        if (flt) res = XLAT_ZERO;
    end
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
    import ptw_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic [31:0] va,
    input  logic [31:0] tbl_base,
    output logic        busy,
    output logic        mem_req,
    output logic [31:0] mem_addr,
    input  logic        mem_rvalid,
    input  logic [31:0] mem_rdata,
    output logic        done,
    output logic        fault,
    output logic        fault_level,
    output logic [31:0] pa_base,
    output logic [1:0]  map_size,
    output logic [3:0]  domain,
    output logic [7:0]  ap
);
    typedef enum logic [2:0] {
        S_IDLE, S_L1_REQ, S_L1_WAIT, S_L2_REQ, S_L2_WAIT, S_DONE
    } st_e;

    st_e         st_q;
    logic [31:0] va_q, base_q, l1_q;
    logic        fine_q;
    xlat_t       res_q;
    logic        flt_q, lvl_q;

    logic [31:0] l1_addr, l2_addr;
    l1_kind_e    l1_kind;
    xlat_t       sect_res, l2_res;
    logic        l2_flt;

    ptw_addr_gen u_addr (
        .va       (va_q),
        .tbl_base (base_q),
        .l1_desc  (l1_q),
        .fine_sel (fine_q),
        .l1_addr  (l1_addr),
        .l2_addr  (l2_addr)
    );

    ptw_l1_decode u_l1 (
        .desc (mem_rdata),
        .kind (l1_kind),
        .sect (sect_res)
    );

    ptw_l2_decode u_l2 (
        .desc     (mem_rdata),
        .fine_tbl (fine_q),
        .dom_in   (l1_q[8:5]),
        .flt      (l2_flt),
        .res      (l2_res)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= S_IDLE;
            va_q   <= '0;
            base_q <= '0;
            l1_q   <= '0;
            fine_q <= 1'b0;
            res_q  <= XLAT_ZERO;
            flt_q  <= 1'b0;
            lvl_q  <= 1'b0;
        end else begin
            unique case (st_q)
                S_IDLE: if (start) begin
                    va_q   <= va;
                    base_q <= tbl_base;
                    res_q  <= XLAT_ZERO;
                    flt_q  <= 1'b0;
                    lvl_q  <= 1'b0;
                    st_q   <= S_L1_REQ;
                end
                S_L1_REQ: st_q <= S_L1_WAIT;
                S_L1_WAIT: if (mem_rvalid) begin
                    l1_q <= mem_rdata;
                    unique case (l1_kind)
                        L1_SECTION: begin
                            res_q <= sect_res;
                            st_q  <= S_DONE;
                        end
                        L1_COARSE: begin
                            fine_q <= 1'b0;
                            st_q   <= S_L2_REQ;
                        end
                        L1_FINE: begin
                            fine_q <= 1'b1;
                            st_q   <= S_L2_REQ;
                        end
                        default: begin
                            flt_q <= 1'b1;
                            lvl_q <= 1'b0;
                            st_q  <= S_DONE;
                        end
                    endcase
                end
                S_L2_REQ: st_q <= S_L2_WAIT;
                S_L2_WAIT: if (mem_rvalid) begin
                    res_q <= l2_res;
                    flt_q <= l2_flt;
                    lvl_q <= 1'b1;
                    st_q  <= S_DONE;
                end
                S_DONE:  st_q <= S_IDLE;
                default: st_q <= S_IDLE;
            endcase
        end
    end

    always_comb begin
        busy        = (st_q != S_IDLE);
        done        = (st_q == S_DONE);
        mem_req     = (st_q == S_L1_REQ) || (st_q == S_L2_REQ);
        mem_addr    = (st_q == S_L2_REQ) ? l2_addr : l1_addr;
        fault       = done && flt_q;
        fault_level = lvl_q;
        pa_base     = res_q.pa;
        map_size    = res_q.size;
        domain      = res_q.dom;
        ap          = res_q.ap;
    end
endmodule

// File: rtl/ptw_walker_checker.sv
module ptw_walker_checker (
    input logic        clk,
    input logic        rst,
    input logic        busy,
    input logic        mem_req,
    input logic        mem_rvalid,
    input logic        done,
    input logic        fault,
    input logic [31:0] pa_base,
    input logic [1:0]  map_size,
    input logic [3:0]  domain,
    input logic [7:0]  ap
);
    logic outstanding;

    always_ff @(posedge clk) begin
        if (rst)             outstanding <= 1'b0;
        else if (mem_req)    outstanding <= 1'b1;
        else if (mem_rvalid) outstanding <= 1'b0;
    end

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);                                                  // R10
    AST_BUSY_AT_DONE: assert property (@(posedge clk) disable iff (rst)
        done |-> busy);                                                   // R10
    AST_BUSY_FALL_AFTER_DONE: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> $past(done));                                     // R10
    AST_FAULT_ONLY_AT_DONE: assert property (@(posedge clk) disable iff (rst)
        fault |-> done);                                                  // R10
    AST_FAULT_ZERO_RESULT: assert property (@(posedge clk) disable iff (rst)
        fault |-> (pa_base == '0 && map_size == '0 && domain == '0 && ap == '0)); // R9
    AST_REQ_PULSE: assert property (@(posedge clk) disable iff (rst)
        mem_req |=> !mem_req);                                            // R12
    AST_REQ_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> busy);                                                // R12
    AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> !outstanding);                                        // R12
endmodule

bind ptw_walker ptw_walker_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .busy       (busy),
    .mem_req    (mem_req),
    .mem_rvalid (mem_rvalid),
    .done       (done),
    .fault      (fault),
    .pa_base    (pa_base),
    .map_size   (map_size),
    .domain     (domain),
    .ap         (ap)
);

// File: tb/ptw_walker_bench.sv
module ptw_walker_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [31:0] va = '0, tbl_base = 32'h8000_4000;
    logic        busy, mem_req, done, fault, fault_level;
    logic [31:0] mem_addr, pa_base;
    logic        mem_rvalid;
    logic [31:0] mem_rdata;
    logic [1:0]  map_size;
    logic [3:0]  domain;
    logic [7:0]  ap;

    int applied = 0;
    int miscompares = 0;

    always #4 clk = ~clk;

    ptw_walker u_ptw_walker (
        .clk(clk), .rst(rst), .start(start), .va(va), .tbl_base(tbl_base),
        .busy(busy), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .done(done),
        .fault(fault), .fault_level(fault_level), .pa_base(pa_base),
        .map_size(map_size), .domain(domain), .ap(ap)
    );

    // Memory model: returns word_a for the first read, word_b for the second.
    logic [31:0] word_a = '0, word_b = '0;
    int          lat = 1;
    logic        clr = 1'b0;
    logic [1:0]  nreads;
    logic [31:0] addr0, addr1;
    logic        pend;
    int          cnt;

    always @(posedge clk) begin
        mem_rvalid <= 1'b0;
        if (rst || clr) begin
            nreads <= '0; pend <= 1'b0; cnt <= 0;
            addr0 <= '0; addr1 <= '0; mem_rdata <= '0;
        end else begin
            if (mem_req) begin
                if (nreads == 2'd0) addr0 <= mem_addr; else addr1 <= mem_addr;
                nreads <= nreads + 2'd1;
                pend   <= 1'b1;
                cnt    <= lat;
            end else if (pend) begin
                if (cnt <= 1) begin
                    mem_rvalid <= 1'b1;
                    mem_rdata  <= (nreads == 2'd1) ? word_a : word_b;
                    pend       <= 1'b0;
                end else cnt <= cnt - 1;
            end
        end
    end

    typedef struct packed {
        logic [31:0] va, w1, w2, a1, a2, pa;
        logic [1:0]  sz;
        logic [3:0]  dom;
        logic [7:0]  ap;
        logic        flt, lvl;
        logic [1:0]  nrd;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        // section (R2, R3)
        '{32'h1234_5678, 32'hABC0_08A2, 32'h0, 32'h8000_448C, 32'h0, 32'hABC0_0000, 2'd0, 4'h5, 8'hAA, 1'b0, 1'b0, 2'd1},
        // coarse -> large (R4, R6)
        '{32'hFFF3_2100, 32'h1234_5581, 32'h7654_0E41, 32'h8000_7FFC, 32'h1234_54C8, 32'h7654_0000, 2'd1, 4'hC, 8'hE4, 1'b0, 1'b0, 2'd2},
        // coarse -> small (R4, R6)
        '{32'h0000_0000, 32'h0000_0C01, 32'h9ABC_D1B2, 32'h8000_4000, 32'h0000_0C00, 32'h9ABC_D000, 2'd2, 4'h0, 8'h1B, 1'b0, 1'b0, 2'd2},
        // fine -> tiny (R5, R7)
        '{32'h0010_0C00, 32'h5555_51E3, 32'h3333_3C13, 32'h8000_4004, 32'h5555_500C, 32'h3333_3C00, 2'd3, 4'hF, 8'h55, 1'b0, 1'b0, 2'd2},
        // fine -> large (R5, R6)
        '{32'h00FF_FC00, 32'h000F_F023, 32'h1000_0FF1, 32'h8000_403C, 32'h000F_FFFC, 32'h1000_0000, 2'd1, 4'h1, 8'hFF, 1'b0, 1'b0, 2'd2},
        // first-level fault (R8)
        '{32'h4000_0000, 32'hFFFF_FFFC, 32'h0, 32'h8000_5000, 32'h0, 32'h0, 2'd0, 4'h0, 8'h00, 1'b1, 1'b0, 2'd1},
        // second-level fault type 00 (R9)
        '{32'h0000_0000, 32'h0000_0C01, 32'h1234_5670, 32'h8000_4000, 32'h0000_0C00, 32'h0, 2'd0, 4'h0, 8'h00, 1'b1, 1'b1, 2'd2},
        // tiny code in a coarse table (R9)
        '{32'h0000_0000, 32'h0000_0C01, 32'h3333_3C13, 32'h8000_4000, 32'h0000_0C00, 32'h0, 2'd0, 4'h0, 8'h00, 1'b1, 1'b1, 2'd2},
        // fine -> small (R5, R6)
        '{32'h0010_0C00, 32'h5555_51E3, 32'h9ABC_D1B2, 32'h8000_4004, 32'h5555_500C, 32'h9ABC_D000, 2'd2, 4'hF, 8'h1B, 1'b0, 1'b0, 2'd2}
    };

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        applied++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Run one walk; optionally pulse start again mid-walk with another address.
    task automatic run(input vec_t v, input int l, input bit poke);
        int guard;
        @(negedge clk);
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
        word_a = v.w1; word_b = v.w2; lat = l;
        va = v.va; start = 1'b1;
        @(negedge clk);
        start = 1'b0; va = 32'hDEAD_BEEF;
        chk(busy === 1'b1, "R10 busy after start", {31'b0, busy}, 32'd1);
        if (poke) begin
            @(negedge clk);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        guard = 0;
        while (done !== 1'b1 && guard < 200) begin
            chk(busy === 1'b1, "R10 busy held", {31'b0, busy}, 32'd1);
            @(negedge clk);
            guard++;
        end
        chk(done === 1'b1, "R10 done seen", {31'b0, done}, 32'd1);
        chk(fault === v.flt, v.flt ? "R8/R9 fault" : "R3/R6 no fault", {31'b0, fault}, {31'b0, v.flt});
        if (v.flt) chk(fault_level === v.lvl, v.lvl ? "R9 level" : "R8 level", {31'b0, fault_level}, {31'b0, v.lvl});
        chk(pa_base === v.pa, "R3/R6/R7 pa_base", pa_base, v.pa);
        chk(map_size === v.sz, "R3/R6/R7 map_size", {30'b0, map_size}, {30'b0, v.sz});
        chk(domain === v.dom, "R4/R5 domain", {28'b0, domain}, {28'b0, v.dom});
        chk(ap === v.ap, "R3/R7 ap", {24'b0, ap}, {24'b0, v.ap});
        chk(addr0 === v.a1, "R2 first address", addr0, v.a1);
        if (v.nrd == 2'd2) chk(addr1 === v.a2, "R4/R5 second address", addr1, v.a2);
        @(negedge clk);
        chk(done === 1'b0 && busy === 1'b0 && fault === 1'b0, "R10 single done",
            {29'b0, done, busy, fault}, 32'd0);
        repeat (4) @(negedge clk);
        chk(nreads === v.nrd, poke ? "R11 read count" : "R12 read count", {30'b0, nreads}, {30'b0, v.nrd});
        if (poke) chk(busy === 1'b0, "R11 no restart", {31'b0, busy}, 32'd0);
    endtask

    initial begin
        #2000000;
        miscompares++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset values
        chk(busy === 1'b0 && done === 1'b0 && fault === 1'b0 && mem_req === 1'b0,
            "R1 reset outputs", {28'b0, busy, done, fault, mem_req}, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        chk(busy === 1'b0 && mem_req === 1'b0, "R1 idle after reset", {30'b0, busy, mem_req}, 32'd0);

        for (int i = 0; i < NV; i++) run(VECS[i], 1 + (i % 3), 1'b0);

        // R11: start pulsed during a two-read walk, and during a section walk
        run(VECS[1], 3, 1'b1);
        run(VECS[0], 4, 1'b1);
        // R12: long latency must not produce a second request early
        run(VECS[3], 9, 1'b0);

        $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
        $finish;
    end
endmodule